// File: doc/BRIEF.md
# Serializer Square-Wave Pattern Generator

This block builds the parallel words fed to a high-speed serializer whose line encoder is switched off, so each word bit reaches the line unchanged and the serial stream forms a square wave. Software-free configuration comes from a few pins. A half-period value sets the wave's period in serial bits. A mode pin selects a 10-bit or a 20-bit word.

A running bit-phase counter is carried from word to word. The wave therefore stays continuous even when its period does not fit a whole number of times into a word.

A phase-select input picks one of M equally spaced copies of the carrier. The choice is latched only on a symbol strobe. This lets a downstream filter recover a phase-shift-keyed carrier: with M = 2 the two copies are half a period apart.

Top module: `sqw_pattern_gen`

## Requirements
- R1: After reset the output word is all zeros and the configuration-error flag is 0. The word stays all zeros until the first cycle in which the symbol strobe is sampled high.
- R2: The period P is 2 × H serial bits, where H is the latched half-period. Word bit 0 is serialized first. Bit i is 0 when (phase + i + offset) mod P < H and 1 otherwise. So H = 1 gives 0101…, H = 2 gives 00110011…, and H = 4 gives 00001111….
- R3: With the mode pin at 0 the word is 10 bits in [9:0] and bits [19:10] are 0. With the mode pin at 1 all 20 bits are used. The mode pin is sampled every cycle and is not gated by the strobe.
- R4: After each emitted word the phase counter advances by the word width, modulo P. The pattern is never restarted at a word boundary.
- R5: A half-period input of 0 is treated as 1. A value above 16 (the MAX_HALF default) is treated as 16.
- R6: Half-period and phase-select inputs are ignored in any cycle without a strobe. The error flag changes only after a strobe.
- R7: For phase selection k (0 ≤ k < M, M = 4 by default), the offset is k × P / M bits.
- R8: When M does not divide P, the error flag reads 1 and the offset is 0. When M divides P, the flag reads 0.
- R9: On a strobe that keeps P unchanged, the phase counter continues. On the first strobe after reset, or on a strobe that changes P, the counter restarts from 0.
- R10: The word registered at the clock edge that samples a strobe already uses the configuration carried by that strobe. There is one register of latency from the inputs to the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_period_i | input | 5 | Requested half-period in serial bits, clamped to 1..16 |
| wide_mode_i | input | 1 | 0: 10-bit word, 1: 20-bit word |
| phase_sel_i | input | 2 | Carrier phase index k, 0..M-1 |
| sym_strobe_i | input | 1 | Symbol strobe; latches half-period and phase select |
| tx_word_o | output | 20 | Parallel word to the serializer, bit 0 sent first |
| cfg_err_o | output | 1 | Latched configuration is invalid (M does not divide P) |

## Verification
The checker watches several properties on every cycle:
- the output stays zero before the first strobe;
- the upper ten bits are zero in narrow mode;
- the internal phase counter stays below the active period;
- the error flag holds between strobes and matches the divisibility of the latched period.

The directed scenarios show what only a word-by-word comparison against a bench model can show:
- the exact bit patterns;
- continuity across words for periods such as 6 and 10;
- clamping;
- the placement of each of the M phase offsets;
- counter restart versus continuation on a strobe.

// File: rtl/sqw_pkg.sv
// Shared constants and types for the square-wave pattern generator.
// Assumes the serializer accepts either a 10-bit or a 20-bit parallel word.
package sqw_pkg;
    localparam int WORD_NARROW = 10;
    localparam int WORD_WIDE   = 20;

    typedef enum logic {
        WIDTH_NARROW = 1'b0,
        WIDTH_WIDE   = 1'b1
    } width_mode_e;
endpackage

// File: rtl/sqw_cfg_latch.sv
// Configuration stage: clamps the requested half-period, derives the
// period, phase offset and validity, and latches them on a symbol strobe.
// Presents the configuration that governs the word built in this cycle.
// Assumes phase_sel_i < PHASES.
module sqw_cfg_latch #(
    parameter int MAX_HALF = 16,
    parameter int PHASES   = 4,
    parameter int HALF_W   = 5,
    parameter int PER_W    = 7,
    parameter int SEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] half_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              stb_i,
    output logic [HALF_W-1:0] nxt_half,
    output logic [PER_W-1:0]  nxt_per,
    output logic [PER_W-1:0]  nxt_off,
    output logic              nxt_armed,
    output logic              restart,
    output logic [PER_W-1:0]  cur_per,
    output logic              cfg_err_o
);
    logic [HALF_W-1:0] clamped;
    logic [PER_W-1:0]  cand_per;
    logic [PER_W-1:0]  cand_step;
    logic [PER_W-1:0]  cand_off;
    logic              cand_ok;
    logic [HALF_W-1:0] act_half;
    logic [PER_W-1:0]  act_per;
    logic [PER_W-1:0]  act_off;
    logic              act_err;
    logic              armed;

    // Clamp the requested half-period into 1..MAX_HALF.
    always_comb begin
        if (half_i == '0)
            clamped = HALF_W'(1);
        else if (half_i > HALF_W'(MAX_HALF))
            clamped = HALF_W'(MAX_HALF);
        else
            clamped = half_i;
    end

    // Candidate period, validity and phase offset from the live inputs.
    always_comb begin
        cand_per  = PER_W'(clamped) << 1;
        cand_ok   = (cand_per % PER_W'(PHASES)) == '0;
        cand_step = cand_per / PER_W'(PHASES);
        cand_off  = cand_ok ? PER_W'(cand_step * PER_W'(sel_i)) : '0;
    end

    // Select the configuration for this word: new on strobe, else held.
    always_comb begin
        nxt_half  = stb_i ? clamped  : act_half;
        nxt_per   = stb_i ? cand_per : act_per;
        nxt_off   = stb_i ? cand_off : act_off;
        nxt_armed = armed | stb_i;
        restart   = stb_i && (!armed || (cand_per != act_per));
    end

    // Hold the active configuration between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_half <= HALF_W'(1);
            act_per  <= PER_W'(2);
            act_off  <= '0;
            act_err  <= 1'b0;
            armed    <= 1'b0;
        end else if (stb_i) begin
            act_half <= clamped;
            act_per  <= cand_per;
            act_off  <= cand_off;
            act_err  <= !cand_ok;
            armed    <= 1'b1;
        end
    end

    assign cur_per   = act_per;
    assign cfg_err_o = act_err;
endmodule

// File: rtl/sqw_bit_lanes.sv
// Bit-lane generator: starting from the word's first bit phase, walks a
// wrap-around position chain across all lanes and slices each position
// against the half-period. Also exposes the position just past the
// narrow and the wide word.
// Assumes base < per and off < per.
module sqw_bit_lanes #(
    parameter int HALF_W = 5,
    parameter int PER_W  = 7,
    parameter int LANES  = 20,
    parameter int TAP_N  = 10
) (
    input  logic [PER_W-1:0]  base,
    input  logic [PER_W-1:0]  off,
    input  logic [PER_W-1:0]  per,
    input  logic [HALF_W-1:0] half,
    output logic [LANES-1:0]  bits,
    output logic [PER_W-1:0]  tap_narrow,
    output logic [PER_W-1:0]  tap_wide
);
    logic [PER_W-1:0] start_sum;
    logic [PER_W-1:0] pos [0:LANES];

    // Fold base + offset back into one period for lane 0.
    always_comb begin
        start_sum = base + off;
        pos[0]    = (start_sum >= per) ? start_sum - per : start_sum;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Next lane's position, wrapping at the period.
        assign pos[g+1] = ((pos[g] + PER_W'(1)) == per) ? '0 : pos[g] + PER_W'(1);
        // Low half of the period emits 0, high half emits 1.
        assign bits[g]  = pos[g] >= PER_W'(half);
    end

    assign tap_narrow = pos[TAP_N];
    assign tap_wide   = pos[LANES];
endmodule

// File: rtl/sqw_phase_acc.sv
// Running bit-phase counter: stores the carrier phase of the next word's
// first bit, excluding the selected phase offset.
// Assumes end_pos < per and off < per.
module sqw_phase_acc #(
    parameter int PER_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             restart,
    input  logic [PER_W-1:0] per,
    input  logic [PER_W-1:0] off,
    input  logic [PER_W-1:0] end_pos,
    output logic [PER_W-1:0] base,
    output logic [PER_W-1:0] phase_q
);
    logic [PER_W-1:0] phase_d;

    // Starting phase for this word; restarts at 0 on a new period.
    assign base = restart ? '0 : phase_q;

    // Remove the offset from the end position to get the carrier phase.
    always_comb begin
        if (end_pos >= off)
            phase_d = end_pos - off;
        else
            phase_d = end_pos + per - off;
    end

    // Advance the counter once per emitted word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (advance)
            phase_q <= phase_d;
    end
endmodule

// File: rtl/sqw_pattern_gen.sv
// Top level: square-wave word generator for an encoder-bypassed serializer.
// Combines the configuration latch, the bit-lane chain and the phase
// counter, and registers the parallel word.
// Assumes the serializer sends bit 0 first.
module sqw_pattern_gen #(
    parameter  int MAX_HALF = 16,
    parameter  int PHASES   = 4,
    localparam int HALF_W   = $clog2(MAX_HALF + 1),
    localparam int PER_W    = $clog2(4 * MAX_HALF + 1),
    localparam int SEL_W    = (PHASES > 1) ? $clog2(PHASES) : 1,
    localparam int WORD_W   = sqw_pkg::WORD_WIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] half_period_i,
    input  logic              wide_mode_i,
    input  logic [SEL_W-1:0]  phase_sel_i,
    input  logic              sym_strobe_i,
    output logic [WORD_W-1:0] tx_word_o,
    output logic              cfg_err_o
);
    import sqw_pkg::*;

    logic [HALF_W-1:0] nxt_half;
    logic [PER_W-1:0]  nxt_per;
    logic [PER_W-1:0]  nxt_off;
    logic [PER_W-1:0]  cur_per;
    logic [PER_W-1:0]  base;
    logic [PER_W-1:0]  phase_q;
    logic [PER_W-1:0]  tap_narrow;
    logic [PER_W-1:0]  tap_wide;
    logic [PER_W-1:0]  end_pos;
    logic              nxt_armed;
    logic              restart;
    logic [WORD_W-1:0] lane_bits;
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] tx_word_q;
    width_mode_e       mode;

    sqw_cfg_latch #(
        .MAX_HALF (MAX_HALF),
        .PHASES   (PHASES),
        .HALF_W   (HALF_W),
        .PER_W    (PER_W),
        .SEL_W    (SEL_W)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_i    (half_period_i),
        .sel_i     (phase_sel_i),
        .stb_i     (sym_strobe_i),
        .nxt_half  (nxt_half),
        .nxt_per   (nxt_per),
        .nxt_off   (nxt_off),
        .nxt_armed (nxt_armed),
        .restart   (restart),
        .cur_per   (cur_per),
        .cfg_err_o (cfg_err_o)
    );

    sqw_bit_lanes #(
        .HALF_W (HALF_W),
        .PER_W  (PER_W),
        .LANES  (WORD_WIDE),
        .TAP_N  (WORD_NARROW)
    ) i_lanes (
        .base       (base),
        .off        (nxt_off),
        .per        (nxt_per),
        .half       (nxt_half),
        .bits       (lane_bits),
        .tap_narrow (tap_narrow),
        .tap_wide   (tap_wide)
    );

    sqw_phase_acc #(
        .PER_W (PER_W)
    ) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (nxt_armed),
        .restart (restart),
        .per     (nxt_per),
        .off     (nxt_off),
        .end_pos (end_pos),
        .base    (base),
        .phase_q (phase_q)
    );

    // Decode the width mode pin.
    assign mode = wide_mode_i ? WIDTH_WIDE : WIDTH_NARROW;

    // Pick the end-of-word position and mask lanes for the active width.
    always_comb begin
        if (mode == WIDTH_WIDE) begin
            end_pos = tap_wide;
            word_d  = lane_bits;
        end else begin
            end_pos = tap_narrow;
            word_d  = {{(WORD_WIDE - WORD_NARROW){1'b0}}, lane_bits[WORD_NARROW-1:0]};
        end
    end

    // Register the parallel word; silent until the first strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_word_q <= '0;
        else if (nxt_armed)
            tx_word_q <= word_d;
        else
            tx_word_q <= '0;
    end

    assign tx_word_o = tx_word_q;
endmodule

// File: rtl/sqw_pattern_gen_chk.sv
// Checker for sqw_pattern_gen: cycle properties on ports and on the
// phase counter. Attached by the bind at the end of this file.
module sqw_pattern_gen_chk #(
    parameter int MAX_HALF = 16,
    parameter int PHASES   = 4,
    parameter int HALF_W   = 5,
    parameter int PER_W    = 7,
    parameter int WORD_W   = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HALF_W-1:0] half_period_i,
    input logic              wide_mode_i,
    input logic              sym_strobe_i,
    input logic [WORD_W-1:0] tx_word_o,
    input logic              cfg_err_o,
    input logic [PER_W-1:0]  phase_q,
    input logic [PER_W-1:0]  cur_per
);
    logic seen_stb;
    int   req_half;
    logic exp_err;

    // Track whether any strobe has been sampled since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_stb <= 1'b0;
        else if (sym_strobe_i)
            seen_stb <= 1'b1;
    end

    // Expected validity of the configuration offered on this cycle.
    always_comb begin
        req_half = int'(half_period_i);
        if (req_half < 1)
            req_half = 1;
        if (req_half > MAX_HALF)
            req_half = MAX_HALF;
        exp_err = ((2 * req_half) % PHASES) != 0;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_stb && !sym_strobe_i) |=> (tx_word_o == '0)); // R1
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_mode_i |=> (tx_word_o[WORD_W-1:10] == '0)); // R3
    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < cur_per); // R4
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_strobe_i |=> $stable(cfg_err_o)); // R6
    AST_ERR_MATCHES_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        sym_strobe_i |=> (cfg_err_o == $past(exp_err))); // R8
endmodule

bind sqw_pattern_gen sqw_pattern_gen_chk #(
    .MAX_HALF (MAX_HALF),
    .PHASES   (PHASES),
    .HALF_W   (HALF_W),
    .PER_W    (PER_W),
    .WORD_W   (WORD_W)
) i_sqw_pattern_gen_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .half_period_i (half_period_i),
    .wide_mode_i   (wide_mode_i),
    .sym_strobe_i  (sym_strobe_i),
    .tx_word_o     (tx_word_o),
    .cfg_err_o     (cfg_err_o),
    .phase_q       (phase_q),
    .cur_per       (cur_per)
);

// File: tb/test_sqw_pattern_gen.sv
// Directed bench for sqw_pattern_gen with a word-level reference model.
module test_sqw_pattern_gen;
    localparam int MAX_HALF = 16;
    localparam int PHASES   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  half_period_i = '0;
    logic        wide_mode_i = 1'b0;
    logic [1:0]  phase_sel_i = '0;
    logic        sym_strobe_i = 1'b0;
    logic [19:0] tx_word_o;
    logic        cfg_err_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    int m_half = 1, m_per = 2, m_off = 0, m_ph = 0;
    bit m_err = 0, m_armed = 0;
    logic [19:0] m_word = '0;

    sqw_pattern_gen #(.MAX_HALF(MAX_HALF), .PHASES(PHASES)) i_sqw_pattern_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .half_period_i (half_period_i),
        .wide_mode_i   (wide_mode_i),
        .phase_sel_i   (phase_sel_i),
        .sym_strobe_i  (sym_strobe_i),
        .tx_word_o     (tx_word_o),
        .cfg_err_o     (cfg_err_o)
    );

    always #4 clk = ~clk;

    task automatic check_val(string tag, logic [19:0] act, logic [19:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One word: model update at the edge, compare at the following negedge.
    task automatic tick(string tag);
        int h, p, w;
        bit ok;
        @(posedge clk);
        if (sym_strobe_i) begin
            h = int'(half_period_i);
            if (h < 1) h = 1;
            if (h > MAX_HALF) h = MAX_HALF;
            p  = 2 * h;
            ok = (p % PHASES) == 0;
            if (!m_armed || p != m_per) m_ph = 0;
            m_half = h; m_per = p; m_err = !ok;
            m_off = ok ? int'(phase_sel_i) * (p / PHASES) : 0;
            m_armed = 1;
        end
        m_word = '0;
        if (m_armed) begin
            w = wide_mode_i ? 20 : 10;
            for (int i = 0; i < w; i++)
                m_word[i] = ((m_ph + i + m_off) % m_per) >= m_half;
            m_ph = (m_ph + w) % m_per;
        end
        @(negedge clk);
        check_val({tag, " word"}, tx_word_o, m_word);
        check_val({tag, " err"}, {19'b0, cfg_err_o}, {19'b0, m_err});
    endtask

    task automatic drive(int h, bit wide, int sel, bit stb);
        half_period_i = 5'(h);
        wide_mode_i   = wide;
        phase_sel_i   = 2'(sel);
        sym_strobe_i  = stb;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_half = 1; m_per = 2; m_off = 0; m_ph = 0; m_err = 0; m_armed = 0;
    endtask

    // R1: zeros after reset and until the first strobe; R6 inputs ignored.
    task automatic t_reset_idle();
        do_reset();
        check_val("R1 reset word", tx_word_o, '0);
        check_val("R1 reset err", {19'b0, cfg_err_o}, '0);
        drive(4, 1, 2, 0);
        repeat (3) tick("R1 idle before strobe");
    endtask

    // R2/R10: literal patterns for half-periods 1, 2 and 4.
    task automatic t_patterns();
        do_reset();
        drive(1, 0, 0, 1);
        tick("R10 first strobed word");
        check_val("R2 half1 literal", tx_word_o, 20'h002AA);
        drive(2, 0, 0, 1);
        tick("R9 restart on new period");
        check_val("R2 half2 literal", tx_word_o, 20'h000CC);
        drive(4, 1, 0, 1);
        tick("R3 wide");
        check_val("R3 half4 wide literal", tx_word_o, 20'h0F0F0);
        drive(4, 0, 0, 0);
        tick("R3 narrow after wide");
    endtask

    // R4: continuity for periods that do not divide the word.
    task automatic t_continuity();
        do_reset();
        drive(3, 0, 0, 1);
        tick("R4 half3 first");
        drive(3, 0, 0, 0);
        repeat (6) tick("R4 half3 narrow");
        drive(5, 1, 0, 1);
        tick("R4 half5 first");
        drive(5, 1, 0, 0);
        repeat (5) tick("R4 half5 wide");
        drive(7, 0, 0, 1);
        tick("R4 half7 first");
        drive(7, 1, 0, 0);
        repeat (3) tick("R4 half7 mixed width");
        drive(7, 0, 0, 0);
        repeat (3) tick("R4 half7 mixed width");
    endtask

    // R5: clamping of out-of-range half-periods.
    task automatic t_clamp();
        do_reset();
        drive(0, 0, 0, 1);
        tick("R5 zero clamps to 1");
        check_val("R5 zero literal", tx_word_o, 20'h002AA);
        drive(25, 1, 0, 1);
        tick("R5 25 clamps to 16");
        check_val("R5 16 literal", tx_word_o, 20'hF0000);
        drive(31, 1, 0, 0);
        repeat (3) tick("R5 period 32 continues");
    endtask

    // R6/R7/R9: phase offsets, held config, continuation on same period.
    task automatic t_phase();
        do_reset();
        drive(4, 1, 0, 1);
        tick("R7 sel0");
        drive(2, 0, 3, 0);
        repeat (3) tick("R6 ignored without strobe");
        for (int k = 1; k < 4; k++) begin
            drive(4, 1, k, 1);
            tick("R7 offset select");
            drive(4, 1, k, 0);
            repeat (2) tick("R9 continue same period");
        end
        drive(8, 0, 2, 1);
        tick("R7 period16 sel2");
        drive(8, 0, 1, 1);
        tick("R9 same period new phase");
    endtask

    // R8: invalid configuration forces offset 0.
    task automatic t_error();
        do_reset();
        drive(3, 0, 1, 1);
        tick("R8 invalid period 6");
        check_val("R8 flag set", {19'b0, cfg_err_o}, 20'h1);
        drive(3, 0, 1, 0);
        repeat (2) tick("R8 offset forced zero");
        drive(4, 0, 1, 1);
        tick("R8 valid again");
        check_val("R8 flag cleared", {19'b0, cfg_err_o}, 20'h0);
    endtask

    initial begin
        t_reset_idle();
        t_patterns();
        t_continuity();
        t_clamp();
        t_phase();
        t_error();
        t_reset_idle();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule